// File: doc/BRIEF.md
# Parallel Bus Master Cycle Sequencer

This block turns single requests from a processor-side register interface into timed read and write cycles on an external 8-bit parallel bus. Each cycle runs through up to three phases: a data setup phase, a strobe phase and a data hold phase. Each phase has its own programmable wait count. The bus pins are a chip select, two control lines, a byte-enable line, an address bus and a byte-wide data bus. The control lines act either as separate read and write strobes or as a read/write select plus an enable strobe.

Software first loads a configuration word and an address. It then issues accesses. A 16-bit access runs as two back-to-back byte transfers to the same address, low byte first. After each access the address can step up or down by one, and bit 14 is left out of the step. A busy flag covers the whole access. Completion is reported by an interrupt pulse, or by a stall signal that holds the requester until the access is over.

Top module: `pbus_master`

## Requirements
- R1: Out of reset, busy, chip select, both control lines, byte enable, data drive enable, irq, stall and the address are all low, and every configuration field is zero (separate strobes, 8-bit, no step, no interrupt, all waits zero).
- R2: With a nonzero strobe wait M, one byte transfer takes (S+1)+(M+1)+(H+1) clock cycles in that order: S is the setup field, M the strobe field and H the hold field. Chip select is high for all of these cycles.
- R3: With strobe wait zero, a byte transfer is one clock cycle with the strobe active, whatever the setup and hold fields hold.
- R4: With cfg_combined=0, bus_rd_rw pulses during the strobe phase of a read and bus_wr_en pulses during the strobe phase of a write. With cfg_combined=1, bus_rd_rw is high for the whole transfer when reading and low when writing, and bus_wr_en is the strobe.
- R5: For a write, bus_doe is high and bus_dout holds the transfer's byte over every cycle of the transfer. For a read, bus_din is captured in the last strobe cycle.
- R6: With cfg_wide=1, one access makes two transfers at one address. The first carries data bits 7:0 with bus_be low, and the second carries bits 15:8 with bus_be high. With cfg_wide=0 there is one transfer and the upper result byte reads zero.
- R7: When an access ends, step mode 01 adds one and mode 10 subtracts one from the 15-bit value formed by address bit 15 above bits 13:0. Bit 14 never changes. Modes 00 and 11 leave the address unchanged.
- R8: busy rises in the cycle after a request is accepted and stays high through the last cycle of the access.
- R9: With irq mode 01, irq pulses for one cycle right after busy falls. With mode 10, cpu_stall equals busy. Other modes raise neither.
- R10: A request, address write or configuration write made while busy is ignored and is not queued. A request made in the same cycle as an address or configuration write is not accepted.
- R11: After a read access, rd_valid pulses for one cycle together with the first idle cycle, and rd_data holds the assembled bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load configuration fields |
| cfg_irq_mode | input | 2 | Completion mode: 00 none, 01 pulse, 10 stall |
| cfg_step_mode | input | 2 | Address step: 00 none, 01 up, 10 down |
| cfg_wide | input | 1 | 1 = 16-bit access as two byte transfers |
| cfg_combined | input | 1 | 1 = read/write select plus enable strobe |
| cfg_setup_wait | input | 2 | Setup phase length minus one |
| cfg_strobe_wait | input | 4 | Extra strobe cycles; zero collapses the transfer |
| cfg_hold_wait | input | 2 | Hold phase length minus one |
| addr_we | input | 1 | Load the address register |
| addr_wdata | input | 16 | Address value to load |
| req_valid | input | 1 | Start an access |
| req_write | input | 1 | 1 = write access |
| req_wdata | input | 16 | Write data for the access |
| cpu_stall | output | 1 | Requester stall (irq mode 10) |
| busy | output | 1 | Access in progress |
| irq | output | 1 | End-of-access pulse (irq mode 01) |
| rd_valid | output | 1 | Read result valid pulse |
| rd_data | output | 16 | Read result |
| bus_cs | output | 1 | Chip select |
| bus_rd_rw | output | 1 | Read strobe, or read/write select in combined style |
| bus_wr_en | output | 1 | Write strobe, or enable strobe in combined style |
| bus_be | output | 1 | High during the upper-byte transfer |
| bus_addr | output | 16 | Address bus |
| bus_dout | output | 8 | Write data byte |
| bus_doe | output | 1 | Data bus drive enable |
| bus_din | input | 8 | Read data byte |

## Verification
The bench builds the block with its default parameters: a 16-bit address and a byte-wide bus, which makes the wait fields 2, 4 and 2 bits. These widths put every wait combination within reach, up to a 48-cycle wide access, and also the address values where the step carries across the skipped bit 14 or borrows out of it. The bench drives read data only while the read strobe is active, so capture outside the strobe shows up as wrong data.

// File: rtl/pbus_pkg.sv
`timescale 1ns/1ps
package pbus_pkg;
    parameter int SETUP_W = 2;
    parameter int STRB_W  = 4;
    parameter int HOLD_W  = 2;

    localparam logic [1:0] IRQ_PULSE = 2'b01;
    localparam logic [1:0] IRQ_STALL = 2'b10;
    localparam logic [1:0] STEP_UP   = 2'b01;
    localparam logic [1:0] STEP_DOWN = 2'b10;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_STRB  = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [1:0]         irq_mode;
        logic [1:0]         step_mode;
        logic               wide;
        logic               combined;
        logic [SETUP_W-1:0] setup;
        logic [STRB_W-1:0]  strb;
        logic [HOLD_W-1:0]  hold;
    } cfg_t;
endpackage

// File: rtl/pbus_addr_step.sv
`timescale 1ns/1ps
module pbus_addr_step #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [1:0]        step_mode,
    output logic [ADDR_W-1:0] addr_out
);
    import pbus_pkg::*;

    localparam int SKIP = ADDR_W - 2;
    localparam int GW   = ADDR_W - 1;

    logic [GW-1:0] gathered;
    logic [GW-1:0] stepped;

    generate
        for (genvar i = 0; i < ADDR_W; i++) begin : g_map
            if (i < SKIP) begin : g_low
                assign gathered[i] = addr_in[i];
                assign addr_out[i] = stepped[i];
            end else if (i == SKIP) begin : g_keep
                assign addr_out[i] = addr_in[i];
            end else begin : g_top
                assign gathered[GW-1] = addr_in[i];
                assign addr_out[i]    = stepped[GW-1];
            end
        end
    endgenerate

    always_comb begin
        unique case (step_mode)
            STEP_UP:   stepped = gathered + GW'(1);
            STEP_DOWN: stepped = gathered - GW'(1);
            default:   stepped = gathered;
        endcase
    end
endmodule

// File: rtl/pbus_regs.sv
`timescale 1ns/1ps
module pbus_regs #(
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 busy,
    input  logic                 cfg_we,
    input  pbus_pkg::cfg_t       cfg_in,
    input  logic                 addr_we,
    input  logic [ADDR_W-1:0]    addr_in,
    input  logic                 step_en,
    input  logic [ADDR_W-1:0]    step_addr,
    output pbus_pkg::cfg_t       cfg_q,
    output logic [ADDR_W-1:0]    addr_q
);
    import pbus_pkg::*;

    typedef struct packed {
        cfg_t              cfg;
        logic [ADDR_W-1:0] addr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!busy && cfg_we) begin
            r_d.cfg = cfg_in;
        end
        if (!busy && addr_we) begin
            r_d.addr = addr_in;
        end else if (step_en) begin
            r_d.addr = step_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_q  = r_q.cfg;
    assign addr_q = r_q.addr;
endmodule

// File: rtl/pbus_engine.sv
`timescale 1ns/1ps
module pbus_engine #(
    parameter int BYTE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wide,
    input  logic                         combined,
    input  logic [pbus_pkg::SETUP_W-1:0] setup_wait,
    input  logic [pbus_pkg::STRB_W-1:0]  strobe_wait,
    input  logic [pbus_pkg::HOLD_W-1:0]  hold_wait,
    input  logic                         start,
    input  logic                         start_write,
    input  logic [2*BYTE_W-1:0]          start_wdata,
    input  logic [BYTE_W-1:0]            bus_din,
    output logic                         busy,
    output logic                         finish,
    output logic                         done_pulse,
    output logic                         done_was_write,
    output logic [2*BYTE_W-1:0]          rdata,
    output logic                         bus_cs,
    output logic                         bus_rd_rw,
    output logic                         bus_wr_en,
    output logic                         bus_be,
    output logic [BYTE_W-1:0]            bus_dout,
    output logic                         bus_doe
);
    import pbus_pkg::*;

    localparam int DW = 2 * BYTE_W;
    localparam int CW = (STRB_W > SETUP_W) ?
                        ((STRB_W > HOLD_W) ? STRB_W : HOLD_W) :
                        ((SETUP_W > HOLD_W) ? SETUP_W : HOLD_W);

    typedef struct packed {
        phase_e          ph;
        logic [CW-1:0]   cnt;
        logic            hi;
        logic            wr;
        logic [DW-1:0]   wdat;
        logic [DW-1:0]   rdat;
        logic            done;
    } eng_t;

    eng_t e_d, e_q;
    logic last_cycle;

    always_comb begin
        e_d        = e_q;
        e_d.done   = 1'b0;
        finish     = 1'b0;
        last_cycle = 1'b0;

        unique case (e_q.ph)
            PH_IDLE: begin
                if (start) begin
                    e_d.hi   = 1'b0;
                    e_d.wr   = start_write;
                    e_d.wdat = start_wdata;
                    if (!start_write) begin
                        e_d.rdat = '0;
                    end
                    if (strobe_wait == '0) begin
                        e_d.ph  = PH_STRB;
                        e_d.cnt = '0;
                    end else begin
                        e_d.ph  = PH_SETUP;
                        e_d.cnt = CW'(setup_wait);
                    end
                end
            end
            PH_SETUP: begin
                if (e_q.cnt == '0) begin
                    e_d.ph  = PH_STRB;
                    e_d.cnt = CW'(strobe_wait);
                end else begin
                    e_d.cnt = e_q.cnt - CW'(1);
                end
            end
            PH_STRB: begin
                if (e_q.cnt == '0) begin
                    if (!e_q.wr) begin
                        if (e_q.hi) begin
                            e_d.rdat[DW-1:BYTE_W] = bus_din;
                        end else begin
                            e_d.rdat[BYTE_W-1:0] = bus_din;
                        end
                    end
                    if (strobe_wait == '0) begin
                        last_cycle = 1'b1;
                    end else begin
                        e_d.ph  = PH_HOLD;
                        e_d.cnt = CW'(hold_wait);
                    end
                end else begin
                    e_d.cnt = e_q.cnt - CW'(1);
                end
            end
            PH_HOLD: begin
                if (e_q.cnt == '0) begin
                    last_cycle = 1'b1;
                end else begin
                    e_d.cnt = e_q.cnt - CW'(1);
                end
            end
            default: e_d.ph = PH_IDLE;
        endcase

        if (last_cycle) begin
            if (wide && !e_q.hi) begin
                e_d.hi = 1'b1;
                if (strobe_wait == '0) begin
                    e_d.ph  = PH_STRB;
                    e_d.cnt = '0;
                end else begin
                    e_d.ph  = PH_SETUP;
                    e_d.cnt = CW'(setup_wait);
                end
            end else begin
                e_d.ph   = PH_IDLE;
                e_d.done = 1'b1;
                finish   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            e_q <= e_d;
        end
    end

    logic strobe_on;
    assign strobe_on      = (e_q.ph == PH_STRB);
    assign busy           = (e_q.ph != PH_IDLE);
    assign done_pulse     = e_q.done;
    assign done_was_write = e_q.wr;
    assign rdata          = e_q.rdat;
    assign bus_cs         = busy;
    assign bus_be         = busy && e_q.hi;
    assign bus_doe        = busy && e_q.wr;
    assign bus_dout       = e_q.hi ? e_q.wdat[DW-1:BYTE_W] : e_q.wdat[BYTE_W-1:0];
    assign bus_rd_rw      = combined ? (busy && !e_q.wr) : (strobe_on && !e_q.wr);
    assign bus_wr_en      = combined ? strobe_on : (strobe_on && e_q.wr);
endmodule

// File: rtl/pbus_master.sv
`timescale 1ns/1ps
module pbus_master #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [1:0]                   cfg_irq_mode,
    input  logic [1:0]                   cfg_step_mode,
    input  logic                         cfg_wide,
    input  logic                         cfg_combined,
    input  logic [pbus_pkg::SETUP_W-1:0] cfg_setup_wait,
    input  logic [pbus_pkg::STRB_W-1:0]  cfg_strobe_wait,
    input  logic [pbus_pkg::HOLD_W-1:0]  cfg_hold_wait,
    input  logic                         addr_we,
    input  logic [ADDR_W-1:0]            addr_wdata,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [2*BYTE_W-1:0]          req_wdata,
    output logic                         cpu_stall,
    output logic                         busy,
    output logic                         irq,
    output logic                         rd_valid,
    output logic [2*BYTE_W-1:0]          rd_data,
    output logic                         bus_cs,
    output logic                         bus_rd_rw,
    output logic                         bus_wr_en,
    output logic                         bus_be,
    output logic [ADDR_W-1:0]            bus_addr,
    output logic [BYTE_W-1:0]            bus_dout,
    output logic                         bus_doe,
    input  logic [BYTE_W-1:0]            bus_din
);
    import pbus_pkg::*;

    cfg_t              cfg_in, cfg_q;
    logic [ADDR_W-1:0] addr_q, addr_next;
    logic              start, finish, done_pulse, done_was_write;

    always_comb begin
        cfg_in.irq_mode  = cfg_irq_mode;
        cfg_in.step_mode = cfg_step_mode;
        cfg_in.wide      = cfg_wide;
        cfg_in.combined  = cfg_combined;
        cfg_in.setup     = cfg_setup_wait;
        cfg_in.strb      = cfg_strobe_wait;
        cfg_in.hold      = cfg_hold_wait;
    end

    assign start = req_valid && !busy && !cfg_we && !addr_we;

    pbus_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .cfg_we    (cfg_we),
        .cfg_in    (cfg_in),
        .addr_we   (addr_we),
        .addr_in   (addr_wdata),
        .step_en   (finish),
        .step_addr (addr_next),
        .cfg_q     (cfg_q),
        .addr_q    (addr_q)
    );

    pbus_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .addr_in   (addr_q),
        .step_mode (cfg_q.step_mode),
        .addr_out  (addr_next)
    );

    pbus_engine #(.BYTE_W(BYTE_W)) u_eng (
        .clk            (clk),
        .rst_n          (rst_n),
        .wide           (cfg_q.wide),
        .combined       (cfg_q.combined),
        .setup_wait     (cfg_q.setup),
        .strobe_wait    (cfg_q.strb),
        .hold_wait      (cfg_q.hold),
        .start          (start),
        .start_write    (req_write),
        .start_wdata    (req_wdata),
        .bus_din        (bus_din),
        .busy           (busy),
        .finish         (finish),
        .done_pulse     (done_pulse),
        .done_was_write (done_was_write),
        .rdata          (rd_data),
        .bus_cs         (bus_cs),
        .bus_rd_rw      (bus_rd_rw),
        .bus_wr_en      (bus_wr_en),
        .bus_be         (bus_be),
        .bus_dout       (bus_dout),
        .bus_doe        (bus_doe)
    );

    assign bus_addr  = addr_q;
    assign irq       = done_pulse && (cfg_q.irq_mode == IRQ_PULSE);
    assign cpu_stall = busy && (cfg_q.irq_mode == IRQ_STALL);
    assign rd_valid  = done_pulse && !done_was_write;
endmodule

// File: rtl/pbus_master_chk.sv
`timescale 1ns/1ps
module pbus_master_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              irq,
    input logic              cpu_stall,
    input logic              bus_rd_rw,
    input logic              bus_wr_en,
    input logic              bus_be,
    input logic              bus_doe,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              combined,
    input logic              wide
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_rd_rw && !bus_wr_en && !bus_doe && !bus_be));

    p_sep_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !combined |-> !(bus_rd_rw && bus_wr_en));

    p_be_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_be |-> wide);

    p_bit14_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bus_addr[ADDR_W-2] == $past(bus_addr[ADDR_W-2])));

    p_irq_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && $past(busy)));

    p_stall_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> busy);

    p_addr_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(bus_addr));
endmodule

bind pbus_master pbus_master_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .irq       (irq),
    .cpu_stall (cpu_stall),
    .bus_rd_rw (bus_rd_rw),
    .bus_wr_en (bus_wr_en),
    .bus_be    (bus_be),
    .bus_doe   (bus_doe),
    .bus_addr  (bus_addr),
    .combined  (cfg_q.combined),
    .wide      (cfg_q.wide)
);

// File: tb/pbus_master_test.sv
`timescale 1ns/1ps
module pbus_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_irq_mode = '0, cfg_step_mode = '0;
    logic        cfg_wide = 1'b0, cfg_combined = 1'b0;
    logic [1:0]  cfg_setup_wait = '0, cfg_hold_wait = '0;
    logic [3:0]  cfg_strobe_wait = '0;
    logic        addr_we = 1'b0;
    logic [15:0] addr_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        cpu_stall, busy, irq, rd_valid;
    logic [15:0] rd_data, bus_addr;
    logic        bus_cs, bus_rd_rw, bus_wr_en, bus_be, bus_doe;
    logic [7:0]  bus_dout, bus_din;

    int tests = 0;
    int fails = 0;

    logic [1:0] s_irq, s_step, s_setup, s_hold;
    logic       s_wide, s_comb;
    logic [3:0] s_strb;
    logic [15:0] s_addr;

    always #2.5 clk = ~clk;

    pbus_master uut (.*);

    function automatic logic [7:0] rbyte(input logic [15:0] a, input logic hi);
        return a[7:0] ^ a[15:8] ^ (hi ? 8'h5A : 8'hC3);
    endfunction

    function automatic logic [15:0] exp_step(input logic [15:0] a, input logic [1:0] m);
        logic [14:0] g;
        g = {a[15], a[13:0]};
        if (m == 2'b01) g = g + 15'd1;
        else if (m == 2'b10) g = g - 15'd1;
        return {g[14], a[14], g[13:0]};
    endfunction

    function automatic int xfer_len(input logic [1:0] s, input logic [3:0] m, input logic [1:0] h);
        if (m == 4'd0) return 1;
        return (int'(s) + 1) + (int'(m) + 1) + (int'(h) + 1);
    endfunction

    logic rd_strobe_seen;
    assign rd_strobe_seen = s_comb ? (bus_wr_en && bus_rd_rw) : bus_rd_rw;
    assign bus_din = rd_strobe_seen ? rbyte(bus_addr, bus_be) : 8'hEE;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] irqm, input logic [1:0] stepm, input logic w,
                           input logic cmb, input logic [1:0] s, input logic [3:0] m,
                           input logic [1:0] h);
        @(negedge clk);
        cfg_we = 1'b1; cfg_irq_mode = irqm; cfg_step_mode = stepm; cfg_wide = w;
        cfg_combined = cmb; cfg_setup_wait = s; cfg_strobe_wait = m; cfg_hold_wait = h;
        s_irq = irqm; s_step = stepm; s_wide = w; s_comb = cmb;
        s_setup = s; s_strb = m; s_hold = h;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_addr(input logic [15:0] a);
        @(negedge clk);
        addr_we = 1'b1; addr_wdata = a; s_addr = a;
        @(negedge clk);
        addr_we = 1'b0;
    endtask

    task automatic access(input logic wr, input logic [15:0] data, input logic disturb);
        int len, total, cyc, t, w, sp, sl;
        int strobe_err, data_err, be_err, irq_cnt, stall_cnt;
        logic in_strb, e_rd, e_wr;
        logic [7:0] e_byte;
        logic [15:0] e_rdata;
        logic ended;
        len = xfer_len(s_setup, s_strb, s_hold);
        total = s_wide ? 2 * len : len;
        sp = (s_strb == 4'd0) ? 0 : int'(s_setup) + 1;
        sl = int'(s_strb) + 1;
        strobe_err = 0; data_err = 0; be_err = 0; irq_cnt = 0; stall_cnt = 0;
        cyc = 0; ended = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wdata = data;
        while (!ended && cyc < 200) begin
            @(negedge clk);
            req_valid = 1'b0; addr_we = 1'b0; cfg_we = 1'b0;
            if (irq) irq_cnt++;
            if (busy) begin
                t = cyc / len; w = cyc % len;
                in_strb = (w >= sp) && (w < sp + sl);
                if (s_comb) begin e_rd = !wr; e_wr = in_strb; end
                else begin e_rd = in_strb && !wr; e_wr = in_strb && wr; end
                if (bus_rd_rw !== e_rd || bus_wr_en !== e_wr || bus_cs !== 1'b1) strobe_err++;
                e_byte = (t == 1) ? data[15:8] : data[7:0];
                if (bus_doe !== wr || (wr && bus_dout !== e_byte)) data_err++;
                if (bus_be !== (s_wide && t == 1)) be_err++;
                if (cpu_stall) stall_cnt++;
                cyc++;
                if (disturb && cyc == 1) begin
                    req_valid = 1'b1; req_write = !wr; req_wdata = ~data;
                    addr_we = 1'b1; addr_wdata = ~s_addr;
                    cfg_we = 1'b1; cfg_wide = !s_wide; cfg_strobe_wait = ~s_strb;
                end
            end else begin
                ended = 1'b1;
            end
        end
        chk(s_strb == 0 ? "R3 transfer length" : "R2 transfer length", cyc, total);
        chk("R8 busy span", cyc, total);
        chk("R4 strobe pins", strobe_err, 0);
        chk("R5 write data drive", data_err, 0);
        chk("R6 byte enable", be_err, 0);
        if (!wr) begin
            e_rdata = {s_wide ? rbyte(s_addr, 1'b1) : 8'h00, rbyte(s_addr, 1'b0)};
            chk("R11 rd_valid", rd_valid, 1);
            chk("R5 R6 R11 read data", rd_data, e_rdata);
        end
        s_addr = exp_step(s_addr, s_step);
        chk("R7 address step", bus_addr, s_addr);
        @(negedge clk);
        if (irq) irq_cnt++;
        chk("R9 irq pulses", irq_cnt, (s_irq == 2'b01) ? 1 : 0);
        chk("R9 stall cycles", stall_cnt, (s_irq == 2'b10) ? total : 0);
        chk("R10 no queued request", busy, 0);
        chk("R11 rd_valid single", rd_valid, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        s_irq = 0; s_step = 0; s_setup = 0; s_hold = 0; s_wide = 0; s_comb = 0;
        s_strb = 0; s_addr = 0;
        #12;
        @(negedge clk);
        chk("R1 busy reset", busy, 0);
        chk("R1 pins reset", {bus_cs, bus_rd_rw, bus_wr_en, bus_be, bus_doe}, 0);
        chk("R1 irq stall reset", {irq, cpu_stall}, 0);
        chk("R1 addr reset", bus_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: zero config -> single-cycle 8-bit read, no step
        access(1'b0, 16'h0000, 1'b0);
        access(1'b1, 16'h12A5, 1'b0);

        // R3: setup and hold ignored with zero strobe wait
        set_cfg(2'b01, 2'b01, 1'b0, 1'b0, 2'd3, 4'd0, 2'd3);
        set_addr(16'h3FFF);
        access(1'b1, 16'h00C7, 1'b0);
        // R2 / R4 separate strobes, full phases
        set_cfg(2'b01, 2'b10, 1'b0, 1'b0, 2'd1, 4'd3, 2'd2);
        set_addr(16'h4000);
        access(1'b0, 16'h0000, 1'b0);
        // R6 wide, R4 combined style, R9 stall
        set_cfg(2'b10, 2'b01, 1'b1, 1'b1, 2'd0, 4'd1, 2'd0);
        set_addr(16'hBFFF);
        access(1'b1, 16'hBEEF, 1'b0);
        access(1'b0, 16'h0000, 1'b0);
        // R10 disturbance while busy
        set_cfg(2'b01, 2'b01, 1'b1, 1'b0, 2'd2, 4'd15, 2'd3);
        set_addr(16'h0101);
        access(1'b1, 16'h5AA5, 1'b1);
        access(1'b0, 16'h0000, 1'b1);
        // R10: request in the same cycle as a config write is dropped
        @(negedge clk);
        cfg_we = 1'b1; req_valid = 1'b1; req_write = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        chk("R10 same-cycle cfg write", busy, 0);
        @(negedge clk);
        addr_we = 1'b1; addr_wdata = s_addr; req_valid = 1'b1;
        @(negedge clk);
        addr_we = 1'b0; req_valid = 1'b0;
        chk("R10 same-cycle addr write", busy, 0);
        // R7 step mode 11 leaves address
        set_cfg(2'b00, 2'b11, 1'b0, 1'b0, 2'd0, 4'd2, 2'd1);
        access(1'b1, 16'h0033, 1'b0);

        for (int i = 0; i < 60; i++) begin
            if (i % 3 == 0) begin
                set_cfg(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                        1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                        2'($urandom_range(0, 3)),
                        ($urandom_range(0, 3) == 0) ? 4'd0 : 4'($urandom_range(0, 15)),
                        2'($urandom_range(0, 3)));
            end
            if (i % 5 == 0) set_addr(16'($urandom));
            access(1'($urandom_range(0, 1)), 16'($urandom), 1'($urandom_range(0, 3) == 0));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule